// File: doc/BRIEF.md
# Tuner Synthesizer Frame Sequencer

This block keeps a tuner's frequency synthesizer programmed by sending it the same short write transaction again and again. Each transaction is one address byte followed by four data bytes. The data bytes carry a 15-bit divider, the charge-pump current select, two reference-divider select bits and a 4-bit band field. The block does not drive the two-wire bus pins. It hands each byte, with markers for the start and stop conditions, to an external bit-level engine over a valid/ready handshake. The engine later reports whether the target acknowledged that byte.

A free-running slot timer marks one slot boundary every `PERIOD_CYCLES` clocks. With the default value this is 20 ms at 50 MHz. At a boundary the sequencer starts a new transaction if it is idle and neither `standby` nor `bus_release` is high. The tuning inputs are copied into a holding register at that moment, so later changes to them wait for the next transaction. A transaction that has begun always runs to its end. If the target does not acknowledge a byte, the transaction is cut short with a stop condition and an error flag is raised. The next attempt happens at the following slot boundary.

Top module: `tuner_frame_seq`

## Requirements
- R1: The first command of every transaction carries byte 0xC2 (parameter `ADDR_BYTE`) with `cmd_start`=1. No later command of that transaction has `cmd_start`=1.
- R2: The second byte is {1'b0, divider[14:8]} and the third byte is divider[7:0].
- R3: The fourth byte is {1, cp_high, 0, 0, 1, ref_sel_a, ref_sel_b, 0}, written MSB first.
- R4: The fifth byte is {4'b0000, band[3:0]} and is the only byte sent with `cmd_stop`=1 in a fully acknowledged transaction.
- R5: After reset the block is idle, with `cmd_valid`=0, `busy`=0 and `frame_err`=0. A transaction starts only at a slot boundary. The boundary falls on the clock edge that ends every `PERIOD_CYCLES`-th cycle after reset, and `cmd_valid` rises in the cycle after that edge.
- R6: If `standby` or `bus_release` is high at a slot boundary, no command is issued during that slot.
- R7: The byte values come from the inputs sampled at the slot boundary that started the transaction. Input changes during the transaction do not affect them.
- R8: Raising `standby` or `bus_release` during a transaction does not shorten it.
- R9: If a non-final byte is not acknowledged (`rsp_done`=1, `rsp_ack`=0), its remaining bytes are dropped. A single stop-only command follows (`cmd_nodata`=1, `cmd_stop`=1, `cmd_start`=0), and `frame_err` is 1 from the next cycle. If the final byte is not acknowledged, no stop-only command follows, because that byte already carried the stop, but `frame_err` is still set.
- R10: `frame_err` stays set until a later transaction has all five bytes acknowledged. It clears in the cycle after the last acknowledgement.
- R11: While `cmd_valid`=1 and `cmd_ready`=0, the command fields keep their values in the next cycle and `cmd_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| divider | input | 15 | Synthesizer programmable divider value |
| ref_sel_a | input | 1 | Reference divider select, upper bit |
| ref_sel_b | input | 1 | Reference divider select, lower bit |
| cp_high | input | 1 | Charge-pump high-current select |
| band | input | 4 | Band switch field |
| standby | input | 1 | Receiver in standby; new transactions are inhibited |
| bus_release | input | 1 | Bus handed to an external tool; new transactions are inhibited |
| cmd_valid | output | 1 | Command offered to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_byte | output | 8 | Byte to transmit |
| cmd_start | output | 1 | Precede this byte with a start condition |
| cmd_stop | output | 1 | Follow this command with a stop condition |
| cmd_nodata | output | 1 | Stop-only command; no byte is sent and no response follows |
| rsp_done | input | 1 | Byte engine finished a byte (one-cycle pulse) |
| rsp_ack | input | 1 | Target acknowledged the byte, qualified by rsp_done |
| busy | output | 1 | A transaction is in progress |
| frame_err | output | 1 | The last transaction ended on a missing acknowledge |

## Verification
The bench builds the block with `PERIOD_CYCLES`=200 instead of the 20 ms default. This lets about a dozen slot boundaries fit in a short run, so several back-to-back refreshes, inhibited slots and error-recovery slots can all be observed. A model in the bench emulates the byte engine with a fixed response latency, a stalling ready pattern and a selectable byte position that is not acknowledged. This covers both the aborted-middle case and the failed-final-byte case. The default address byte is kept, so the first byte on the wire is the real target address.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int DIV_W       = 15;
    localparam int BAND_W      = 4;
    localparam int FRAME_BYTES = 5;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    // Tuning word held for the duration of one transaction.
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic              rsa;
        logic              rsb;
        logic              cp;
        logic [BAND_W-1:0] band;
    } tune_word_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SEND  = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_ABORT = 2'd3
    } seq_state_t;

    // One command toward the bit-level engine.
    typedef struct packed {
        logic [7:0] data;
        logic       start;
        logic       stop;
        logic       nodata;
    } bus_cmd_t;

    // Byte at position pos of the transaction.
    function automatic logic [7:0] frame_byte(tune_word_t w, int pos, logic [7:0] addr);
        logic [7:0] b;
        case (pos)
            0:       b = addr;
            1:       b = {1'b0, w.div[14:8]};
            2:       b = w.div[7:0];
            3:       b = {1'b1, w.cp, 2'b00, 1'b1, w.rsa, w.rsb, 1'b0};
            default: b = {4'b0000, w.band};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tfs_slot_timer.sv
module tfs_slot_timer #(
    parameter int PERIOD_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic slot_tick
);
    localparam int CW = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(PERIOD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign slot_tick = (cnt == LAST_CNT);

endmodule

// File: rtl/tfs_frame_store.sv
module tfs_frame_store
    import tfs_pkg::*;
#(
    parameter logic [7:0] ADDR_BYTE = 8'hC2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  tune_word_t             word_in,
    input  logic [IDX_W-1:0]       sel,
    output logic [7:0]             byte_out
);
    tune_word_t held;
    logic [7:0] bytes [FRAME_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= word_in;
        end
    end

    for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_byte
        assign bytes[g] = frame_byte(held, g, ADDR_BYTE);
    end

    always_comb begin
        byte_out = bytes[FRAME_BYTES-1];
        for (int k = 0; k < FRAME_BYTES; k++) begin
            if (sel == IDX_W'(k)) byte_out = bytes[k];
        end
    end

endmodule

// File: rtl/tfs_byte_sequencer.sv
module tfs_byte_sequencer
    import tfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_tick,
    input  logic             inhibit,
    input  logic [7:0]       cur_byte,
    input  logic             cmd_ready,
    input  logic             rsp_done,
    input  logic             rsp_ack,
    output logic             load,
    output logic [IDX_W-1:0] sel,
    output logic             cmd_valid,
    output bus_cmd_t         cmd,
    output logic             busy,
    output logic             frame_err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    seq_state_t       state, state_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic             err_n;

    assign load = (state == SQ_IDLE) && slot_tick && !inhibit;

    always_comb begin
        state_n = state;
        idx_n   = idx;
        err_n   = frame_err;
        case (state)
            SQ_IDLE: begin
                if (load) begin
                    state_n = SQ_SEND;
                    idx_n   = '0;
                end
            end
            SQ_SEND: begin
                if (cmd_ready) state_n = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (rsp_done) begin
                    if (!rsp_ack) begin
                        err_n   = 1'b1;
                        state_n = (idx == LAST_IDX) ? SQ_IDLE : SQ_ABORT;
                    end else if (idx == LAST_IDX) begin
                        err_n   = 1'b0;
                        state_n = SQ_IDLE;
                    end else begin
                        idx_n   = idx + 1'b1;
                        state_n = SQ_SEND;
                    end
                end
            end
            SQ_ABORT: begin
                if (cmd_ready) state_n = SQ_IDLE;
            end
            default: state_n = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            idx       <= '0;
            frame_err <= 1'b0;
        end else begin
            state     <= state_n;
            idx       <= idx_n;
            frame_err <= err_n;
        end
    end

    assign sel       = idx;
    assign busy      = (state != SQ_IDLE);
    assign cmd_valid = (state == SQ_SEND) || (state == SQ_ABORT);

    always_comb begin
        cmd        = '0;
        cmd.nodata = (state == SQ_ABORT);
        cmd.start  = (state == SQ_SEND) && (idx == '0);
        cmd.stop   = ((state == SQ_SEND) && (idx == LAST_IDX)) || (state == SQ_ABORT);
        cmd.data   = (state == SQ_SEND) ? cur_byte : 8'h00;
    end

endmodule

// File: rtl/tuner_frame_seq.sv
module tuner_frame_seq
    import tfs_pkg::*;
#(
    parameter int         PERIOD_CYCLES = 1_000_000,
    parameter logic [7:0] ADDR_BYTE     = 8'hC2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [14:0] divider,
    input  logic        ref_sel_a,
    input  logic        ref_sel_b,
    input  logic        cp_high,
    input  logic [3:0]  band,
    input  logic        standby,
    input  logic        bus_release,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [7:0]  cmd_byte,
    output logic        cmd_start,
    output logic        cmd_stop,
    output logic        cmd_nodata,
    input  logic        rsp_done,
    input  logic        rsp_ack,
    output logic        busy,
    output logic        frame_err
);
    logic             slot_tick;
    logic             load;
    logic [IDX_W-1:0] sel;
    logic [7:0]       cur_byte;
    tune_word_t       word_in;
    bus_cmd_t         cmd;

    assign word_in = '{div: divider, rsa: ref_sel_a, rsb: ref_sel_b, cp: cp_high, band: band};

    tfs_slot_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .slot_tick (slot_tick)
    );

    tfs_frame_store #(.ADDR_BYTE(ADDR_BYTE)) u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .word_in  (word_in),
        .sel      (sel),
        .byte_out (cur_byte)
    );

    tfs_byte_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .slot_tick (slot_tick),
        .inhibit   (standby | bus_release),
        .cur_byte  (cur_byte),
        .cmd_ready (cmd_ready),
        .rsp_done  (rsp_done),
        .rsp_ack   (rsp_ack),
        .load      (load),
        .sel       (sel),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .busy      (busy),
        .frame_err (frame_err)
    );

    assign cmd_byte   = cmd.data;
    assign cmd_start  = cmd.start;
    assign cmd_stop   = cmd.stop;
    assign cmd_nodata = cmd.nodata;

endmodule

// File: rtl/tuner_frame_seq_chk.sv
module tuner_frame_seq_chk #(
    parameter logic [7:0] ADDR_BYTE = 8'hC2
) (
    input logic       clk,
    input logic       rst,
    input logic       standby,
    input logic       bus_release,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_byte,
    input logic       cmd_start,
    input logic       cmd_stop,
    input logic       cmd_nodata,
    input logic       rsp_done,
    input logic       rsp_ack,
    input logic       busy,
    input logic       frame_err
);
    a_r11_hold_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_start)
                                    && $stable(cmd_stop) && $stable(cmd_nodata));

    a_r1_start_is_addr: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_start |-> cmd_byte == ADDR_BYTE && !cmd_nodata);

    a_r9_abort_shape: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_nodata |-> cmd_stop && !cmd_start);

    a_r9_err_on_nack: assert property (@(posedge clk) disable iff (rst)
        busy && !cmd_valid && rsp_done && !rsp_ack |=> frame_err);

    a_r6_no_start_inhibited: assert property (@(posedge clk) disable iff (rst)
        !busy && (standby || bus_release) |=> !busy);

    a_r4_band_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_stop && !cmd_nodata |-> cmd_byte[7:4] == 4'h0);

    a_r5_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);
endmodule

bind tuner_frame_seq tuner_frame_seq_chk #(.ADDR_BYTE(ADDR_BYTE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .standby     (standby),
    .bus_release (bus_release),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_byte    (cmd_byte),
    .cmd_start   (cmd_start),
    .cmd_stop    (cmd_stop),
    .cmd_nodata  (cmd_nodata),
    .rsp_done    (rsp_done),
    .rsp_ack     (rsp_ack),
    .busy        (busy),
    .frame_err   (frame_err)
);

// File: tb/tuner_frame_seq_test.sv
module tuner_frame_seq_test;
    localparam int PER = 200;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] divider = '0;
    logic        ref_sel_a = 1'b0, ref_sel_b = 1'b0, cp_high = 1'b0;
    logic [3:0]  band = '0;
    logic        standby = 1'b0, bus_release = 1'b0;
    logic        cmd_valid, cmd_start, cmd_stop, cmd_nodata, busy, frame_err;
    logic [7:0]  cmd_byte;
    logic        cmd_ready = 1'b0, rsp_done = 1'b0, rsp_ack = 1'b0;

    tuner_frame_seq #(.PERIOD_CYCLES(PER)) uut (
        .clk(clk), .rst(rst), .divider(divider), .ref_sel_a(ref_sel_a),
        .ref_sel_b(ref_sel_b), .cp_high(cp_high), .band(band), .standby(standby),
        .bus_release(bus_release), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_byte(cmd_byte), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cmd_nodata(cmd_nodata), .rsp_done(rsp_done), .rsp_ack(rsp_ack),
        .busy(busy), .frame_err(frame_err)
    );

    always #10 clk = ~clk;   // 50 MHz

    int    tests = 0, fails = 0, cyc = 0;
    bit    finished = 0;
    string cur_tag = "R5";

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic string tag_of(int k);
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            default: return "R9";
        endcase
    endfunction

    // ---------------- reference model ----------------
    typedef struct packed {
        logic [7:0] b;
        logic       s;
        logic       p;
        logic       n;
        logic [3:0] k;
    } exp_t;

    exp_t q[$];
    bit   m_wait = 0, m_last = 0, m_err = 0;
    int   m_t = 0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_wait = 0; m_last = 0; m_err = 0; m_t = 0;
        end else begin
            bit   tick, idle, ev;
            exp_t e;
            tick = ((m_t % PER) == PER - 1);
            m_t++;
            idle = (q.size() == 0) && !m_wait;
            ev   = (q.size() > 0) && !m_wait;
            if (ev && cmd_ready) begin
                e = q.pop_front();
                if (!e.n) begin m_wait = 1; m_last = e.p; end
            end else if (m_wait && rsp_done) begin
                m_wait = 0;
                if (!rsp_ack) begin
                    m_err = 1;
                    q.delete();
                    if (!m_last) q.push_back('{b: 8'h00, s: 1'b0, p: 1'b1, n: 1'b1, k: 4'd5});
                end else if (m_last) begin
                    m_err = 0;
                end
            end
            if (idle && tick && !standby && !bus_release) begin
                q.push_back('{b: 8'hC2, s: 1'b1, p: 1'b0, n: 1'b0, k: 4'd0});
                q.push_back('{b: 8'(divider >> 8), s: 1'b0, p: 1'b0, n: 1'b0, k: 4'd1});
                q.push_back('{b: divider[7:0], s: 1'b0, p: 1'b0, n: 1'b0, k: 4'd2});
                q.push_back('{b: 8'h88 | (8'(cp_high) << 6) | (8'(ref_sel_a) << 2) | (8'(ref_sel_b) << 1),
                              s: 1'b0, p: 1'b0, n: 1'b0, k: 4'd3});
                q.push_back('{b: 8'(band), s: 1'b0, p: 1'b1, n: 1'b0, k: 4'd4});
            end
        end
    end

    // ---------------- byte engine emulation ----------------
    int nack_pos = -1, pos = 0, resp_cnt = 0, starts = 0;
    bit stall = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst && cmd_valid && cmd_ready && !cmd_nodata) begin
            pos = cmd_start ? 0 : pos + 1;
            if (cmd_start) starts++;
            resp_cnt = LAT;
        end
        if (cyc > 100000 && !finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        cmd_ready = stall ? ((cyc % 3) == 2) : 1'b1;
        rsp_done  = 1'b0;
        if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
                rsp_done = 1'b1;
                rsp_ack  = (pos != nack_pos);
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!rst) begin
            bit ev;
            ev = (q.size() > 0) && !m_wait;
            chk(cmd_valid == ev, cur_tag, "cmd_valid", cmd_valid, ev);
            chk(busy == ((q.size() > 0) || m_wait), cur_tag, "busy", busy, (q.size() > 0) || m_wait);
            chk(frame_err == m_err, "R10", "frame_err", frame_err, m_err);
            if (ev && cmd_valid) begin
                chk(cmd_byte == q[0].b, tag_of(q[0].k), "cmd_byte", cmd_byte, q[0].b);
                chk(cmd_start == q[0].s, tag_of(q[0].k), "cmd_start", cmd_start, q[0].s);
                chk(cmd_stop == q[0].p, tag_of(q[0].k), "cmd_stop", cmd_stop, q[0].p);
                chk(cmd_nodata == q[0].n, tag_of(q[0].k), "cmd_nodata", cmd_nodata, q[0].n);
            end
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_busy(bit lvl);
        int guard = 0;
        while (busy !== lvl && guard < 1000) begin @(negedge clk); guard++; end
    endtask

    initial begin
        int s0;
        cycles(3);
        // R5: reset state
        chk(cmd_valid == 0 && busy == 0 && frame_err == 0, "R5", "reset outputs",
            {cmd_valid, busy, frame_err}, 0);
        divider = 15'h1234; cp_high = 1; ref_sel_a = 0; ref_sel_b = 1; band = 4'b0101;
        rst = 0;
        // R5: nothing before the first boundary
        cycles(PER - 2);
        chk(busy == 0, "R5", "busy before first boundary", busy, 0);
        cycles(2);
        chk(busy == 1, "R5", "busy after first boundary", busy, 1);
        wait_busy(0);
        cur_tag = "R7";
        divider = 15'h7ABC; cp_high = 0; ref_sel_a = 1; ref_sel_b = 0; band = 4'b1010;
        stall = 1;
        wait_busy(1);
        cycles(3);
        divider = 15'h0001; band = 4'b1111;   // R7: mid-frame change
        cur_tag = "R8";
        standby = 1;                          // R8: inhibit mid-frame
        wait_busy(0);
        chk(frame_err == 0, "R8", "frame completed", frame_err, 0);
        cur_tag = "R6";
        s0 = starts;
        cycles(PER + 20);
        chk(starts == s0, "R6", "no frame in standby slot", starts, s0);
        standby = 0; bus_release = 1;
        cycles(PER);
        chk(starts == s0, "R6", "no frame in release slot", starts, s0);
        bus_release = 0;
        stall = 0;
        cur_tag = "R9";
        nack_pos = 1;
        wait_busy(1);
        wait_busy(0);
        chk(frame_err == 1, "R9", "err after middle nack", frame_err, 1);
        nack_pos = -1;
        cur_tag = "R10";
        wait_busy(1);
        cycles(2);
        chk(frame_err == 1, "R10", "err held during retry", frame_err, 1);
        wait_busy(0);
        chk(frame_err == 0, "R10", "err cleared by good frame", frame_err, 0);
        cur_tag = "R9";
        nack_pos = 4;
        wait_busy(1);
        wait_busy(0);
        chk(frame_err == 1, "R9", "err after final nack", frame_err, 1);
        nack_pos = -1;
        stall = 1;
        cur_tag = "R11";
        wait_busy(1);
        wait_busy(0);
        chk(frame_err == 0, "R10", "err cleared after stalled frame", frame_err, 0);
        cycles(PER);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule